// File: doc/BRIEF.md
# Dual-Word Serial Converter Capture Controller

This block is the host side of a three-wire link to a serial sampling converter. It divides the system clock down to a serial clock. It raises a conversion-start pulse that is one serial period wide. It then reads two 14-bit results from the serial data line during each 32-period frame. Each result is presented right justified in a 16-bit word. When the second word of a frame has been read, both words update together and a one-cycle valid strobe marks them.

The block is controlled by one state machine with three states: `ST_IDLE`, `ST_LEAD` and `ST_FRAME`.
- `ST_IDLE` moves to `ST_LEAD` when enable is high.
- `ST_LEAD` is one serial period. At its falling edge the conversion start rises. It moves to `ST_FRAME` on the next serial rising edge.
- `ST_FRAME` counts serial periods 0 to 31. Period 0 begins with the first serial rising edge after the start pulse rose.
- At the falling edge of period 31, enable is sampled again:
  - If enable is high, the start pulse rises once more. On the next rising edge the frame restarts at period 0, staying in `ST_FRAME`.
  - If enable is low, the machine returns to `ST_IDLE` at that rising edge. The serial clock then stays low.

Serial data is sampled on the system clock edge at which the serial clock falls.

Top module: `adc_pair_capture`

## Requirements
- R1: While reset is high, and on the first clock after it, the serial clock, the conversion start and the valid strobe are low, and both data words are zero.
- R2: While running, the serial clock has a period of DIV system clocks. It is high for DIV/2 of them, starting at each rising edge. In `ST_IDLE` it stays low.
- R3: The conversion start rises only on the system clock edge at which the serial clock falls. It stays high for exactly DIV system clocks, which is one serial period.
- R4: Between two consecutive rises of the conversion start, the serial clock has at least 32 rising edges. Under continuous enable it has exactly 32.
- R5: The first word is formed from the serial data sampled at the falling edges of frame periods 2 to 15. The period-2 sample is its most significant bit.
- R6: The second word is formed from the samples at the falling edges of periods 18 to 31, most significant bit first. Data during periods 0, 1, 16 and 17 has no effect on either word.
- R7: Each 14-bit result occupies bits 13:0 of its 16-bit word. Bits 15:14 are always zero.
- R8: The valid strobe is high for exactly one system clock. It rises on the same edge as the serial clock fall of period 31, and both words take their new values on that edge.
- R9: Both data words hold their values between valid strobes.
- R10: If enable is low at the falling edge of period 31, the frame completes with its valid strobe. No further conversion start follows, and the serial clock stays low until enable returns. Dropping enable earlier in a frame does not cut it short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run frames while high |
| sdata_i | input | 1 | Serial data from converter |
| sclk_o | output | 1 | Divided serial clock |
| conv_o | output | 1 | Conversion-start pulse |
| word_a_o | output | 16 | First result of the frame, right justified |
| word_b_o | output | 16 | Second result of the frame, right justified |
| valid_o | output | 1 | One-cycle strobe: new word pair |

## Verification
A wrong period index inside the frame shows up at the ports as a result that is shifted by one or more bits. It can also show up as gap data leaking into a word, visible on the first valid strobe, within one frame of about 32·DIV clocks. A wrong state transition shows up as a start pulse of the wrong width, a wrong count of serial rising edges between start pulses, or a serial clock that keeps toggling after enable is dropped. Each of these is visible within the same or the next frame. The converter model in the bench derives its bit timing only from the serial clock and conversion-start pins. Any misalignment therefore surfaces as a data mismatch.

// File: rtl/adc_cap_pkg.sv
`timescale 1ns/1ps
package adc_cap_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_FRAME = 2'd2
    } cap_state_e;

    // Serial periods before the first data bit, and periods of the gap between words
    localparam int DATA_OFFSET = 2;
    localparam int GAP_PERIODS = 2;
endpackage

// File: rtl/adc_cap_sck_gen.sv
`timescale 1ns/1ps
module adc_cap_sck_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    input  logic active,
    input  logic halt,
    output logic sclk,
    output logic rise_en,
    output logic fall_en
);
    localparam int HALF = DIV / 2;
    localparam int CW   = $clog2(DIV);

    logic [CW-1:0] cnt;

    generate
        if (DIV < 2) begin : g_bad_div
            $error("DIV must be at least 2");
        end
    endgenerate

    // single-cycle strobes in the system clock domain
    assign rise_en = active && (cnt == CW'(DIV - 1));
    assign fall_en = active && (cnt == CW'(HALF - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            sclk <= 1'b0;
        end else begin
            if (!active || rise_en) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end

            if (go) begin
                sclk <= 1'b1;
            end else if (rise_en) begin
                sclk <= !halt;
            end else if (fall_en) begin
                sclk <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/adc_cap_word_asm.sv
`timescale 1ns/1ps
module adc_cap_word_asm
    import adc_cap_pkg::*;
#(
    parameter int BITS   = 14,
    parameter int WORD_W = 16,
    parameter int IW     = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sample_en,
    input  logic [IW-1:0]     idx,
    input  logic              sdata,
    output logic [WORD_W-1:0] word_a,
    output logic [WORD_W-1:0] word_b,
    output logic              valid
);
    localparam int A_FIRST = DATA_OFFSET;
    localparam int A_LAST  = A_FIRST + BITS - 1;
    localparam int B_FIRST = A_LAST + 1 + GAP_PERIODS;
    localparam int B_LAST  = B_FIRST + BITS - 1;

    logic [BITS-1:0] shreg;
    logic [BITS-1:0] hold_a;
    logic [BITS-1:0] shifted;
    logic            in_a;
    logic            in_b;

    generate
        if (WORD_W <= BITS) begin : g_bad_width
            $error("WORD_W must exceed BITS");
        end
    endgenerate

    assign in_a    = (int'(idx) >= A_FIRST) && (int'(idx) <= A_LAST);
    assign in_b    = (int'(idx) >= B_FIRST) && (int'(idx) <= B_LAST);
    assign shifted = {shreg[BITS-2:0], sdata};

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg  <= '0;
            hold_a <= '0;
            word_a <= '0;
            word_b <= '0;
            valid  <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (sample_en && (in_a || in_b)) begin
                shreg <= shifted;
                if (int'(idx) == A_LAST) begin
                    hold_a <= shifted;
                end
                if (int'(idx) == B_LAST) begin
                    word_a <= WORD_W'(hold_a);
                    word_b <= WORD_W'(shifted);
                    valid  <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/adc_pair_capture.sv
`timescale 1ns/1ps
module adc_pair_capture
    import adc_cap_pkg::*;
#(
    parameter int DIV    = 4,
    parameter int BITS   = 14,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              sdata_i,
    output logic              sclk_o,
    output logic              conv_o,
    output logic [WORD_W-1:0] word_a_o,
    output logic [WORD_W-1:0] word_b_o,
    output logic              valid_o
);
    localparam int FRAME_SCK = 2 * BITS + DATA_OFFSET + GAP_PERIODS;
    localparam int IW        = $clog2(FRAME_SCK);
    localparam int LAST      = FRAME_SCK - 1;

    cap_state_e    state;
    cap_state_e    state_nx;
    logic [IW-1:0] idx_q;
    logic          conv_q;
    logic          go;
    logic          active;
    logic          halt;
    logic          rise_en;
    logic          fall_en;
    logic          at_last;

    assign go      = (state == ST_IDLE) && en;
    assign active  = (state != ST_IDLE);
    assign at_last = (int'(idx_q) == LAST);
    assign halt    = (state == ST_FRAME) && at_last && !conv_q;

    adc_cap_sck_gen #(.DIV(DIV)) u_sck (
        .clk     (clk),
        .rst     (rst),
        .go      (go),
        .active  (active),
        .halt    (halt),
        .sclk    (sclk_o),
        .rise_en (rise_en),
        .fall_en (fall_en)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (en)              state_nx = ST_LEAD;
            ST_LEAD:  if (rise_en)         state_nx = ST_FRAME;
            ST_FRAME: if (rise_en && halt) state_nx = ST_IDLE;
            default:                       state_nx = ST_IDLE;
        endcase
    end

    // outputs: conversion start and period index
    always_ff @(posedge clk) begin
        if (rst) begin
            conv_q <= 1'b0;
            idx_q  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    conv_q <= 1'b0;
                    idx_q  <= '0;
                end
                ST_LEAD: begin
                    if (fall_en) conv_q <= 1'b1;
                    if (rise_en) idx_q  <= '0;
                end
                ST_FRAME: begin
                    if (fall_en) begin
                        if (int'(idx_q) == 0) conv_q <= 1'b0;
                        else if (at_last)     conv_q <= en;
                    end
                    if (rise_en) begin
                        idx_q <= at_last ? '0 : idx_q + 1'b1;
                    end
                end
                default: begin
                    conv_q <= 1'b0;
                    idx_q  <= '0;
                end
            endcase
        end
    end

    assign conv_o = conv_q;

    adc_cap_word_asm #(
        .BITS   (BITS),
        .WORD_W (WORD_W),
        .IW     (IW)
    ) u_asm (
        .clk       (clk),
        .rst       (rst),
        .sample_en (fall_en && (state == ST_FRAME)),
        .idx       (idx_q),
        .sdata     (sdata_i),
        .word_a    (word_a_o),
        .word_b    (word_b_o),
        .valid     (valid_o)
    );
endmodule

// File: rtl/adc_pair_capture_chk.sv
`timescale 1ns/1ps
module adc_pair_capture_chk #(
    parameter int DIV    = 4,
    parameter int BITS   = 14,
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              sclk,
    input logic              conv,
    input logic              valid,
    input logic [WORD_W-1:0] word_a,
    input logic [WORD_W-1:0] word_b
);
    localparam int FRAME_SCK = 2 * BITS + 4;

    int   conv_hi;
    int   rises;
    logic seen;
    logic sclk_d;
    logic conv_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            conv_hi <= 0;
            rises   <= 0;
            seen    <= 1'b0;
            sclk_d  <= 1'b0;
            conv_d  <= 1'b0;
        end else begin
            sclk_d  <= sclk;
            conv_d  <= conv;
            conv_hi <= conv ? conv_hi + 1 : 0;
            if (conv && !conv_d) begin
                rises <= 0;
                seen  <= 1'b1;
            end else if (sclk && !sclk_d) begin
                rises <= rises + 1;
            end
        end
    end

    a_r8_valid_single: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

    a_r3_conv_on_fall: assert property (@(posedge clk) disable iff (rst)
        $rose(conv) |-> !sclk);

    a_r3_conv_width: assert property (@(posedge clk) disable iff (rst)
        $fell(conv) |-> conv_hi == DIV);

    a_r4_frame_length: assert property (@(posedge clk) disable iff (rst)
        ($rose(conv) && seen) |-> rises >= FRAME_SCK);

    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !valid |-> ($stable(word_a) && $stable(word_b)));

    a_r7_justified: assert property (@(posedge clk) disable iff (rst)
        ((word_a >> BITS) == '0) && ((word_b >> BITS) == '0));
endmodule

bind adc_pair_capture adc_pair_capture_chk #(
    .DIV    (DIV),
    .BITS   (BITS),
    .WORD_W (WORD_W)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .sclk   (sclk_o),
    .conv   (conv_o),
    .valid  (valid_o),
    .word_a (word_a_o),
    .word_b (word_b_o)
);

// File: tb/adc_pair_capture_bench.sv
`timescale 1ns/1ps
module adc_pair_capture_bench;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        sdata = 1'b0;
    logic        sclk_o;
    logic        conv_o;
    logic [15:0] word_a_o;
    logic [15:0] word_b_o;
    logic        valid_o;

    int checks = 0;
    int errors = 0;

    // converter model state
    logic [13:0] mdl_a = '0;
    logic [13:0] mdl_b = '0;
    logic [13:0] sh_a = '0;
    logic [13:0] sh_b = '0;
    logic        gap_val = 1'b0;
    int          kcnt = 0;

    int      nconv = 0;
    int      nrise = 0;
    int      last_gap = 0;
    realtime t_fall = 0;
    realtime t_valid = 0;

    always #2 clk = ~clk;

    adc_pair_capture u_adc_pair_capture (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .sdata_i  (sdata),
        .sclk_o   (sclk_o),
        .conv_o   (conv_o),
        .word_a_o (word_a_o),
        .word_b_o (word_b_o),
        .valid_o  (valid_o)
    );

    always @(posedge conv_o) begin
        kcnt = 0;
        sh_a = mdl_a;
        sh_b = mdl_b;
        nconv++;
        last_gap = nrise;
        nrise = 0;
    end

    always @(posedge sclk_o) begin
        kcnt++;
        nrise++;
        #1;
        if (kcnt >= 3 && kcnt <= 16)       sdata = sh_a[16 - kcnt];
        else if (kcnt >= 19 && kcnt <= 32) sdata = sh_b[32 - kcnt];
        else                               sdata = gap_val ^ kcnt[0];
    end

    always @(negedge sclk_o) t_fall = $realtime;
    always @(posedge valid_o) t_valid = $realtime;

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_valid(output logic seen);
        seen = 1'b0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (valid_o) begin
                seen = 1'b1;
                break;
            end
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(!sclk_o && !conv_o && !valid_o, "R1 controls", {sclk_o, conv_o, valid_o}, 0);
        chk(word_a_o == 0 && word_b_o == 0, "R1 words", word_a_o, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!sclk_o && !conv_o && word_a_o == 0, "R1 after release", {sclk_o, conv_o}, 0);
        begin
            int toggles = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (sclk_o || conv_o) toggles++;
            end
            chk(toggles == 0, "R2 idle low", toggles, 0);
        end
    endtask

    task automatic t_timing();
        int hi = 0;
        int lo = 0;
        int cw = 0;
        logic seen;
        mdl_a = 14'h0123;
        mdl_b = 14'h0456;
        @(negedge clk) en = 1'b1;
        @(posedge conv_o);
        @(negedge clk);
        en = 1'b0;
        chk(!sclk_o, "R3 conv rises with sclk fall", sclk_o, 0);
        cw = 1;
        while (conv_o) begin
            @(negedge clk);
            if (conv_o) cw++;
        end
        chk(cw == DIV, "R3 conv width", cw, DIV);
        @(posedge sclk_o);
        @(negedge clk);
        while (sclk_o) begin hi++; @(negedge clk); end
        while (!sclk_o) begin lo++; @(negedge clk); end
        chk(hi == DIV / 2, "R2 sclk high", hi, DIV / 2);
        chk(lo == DIV - DIV / 2, "R2 sclk low", lo, DIV - DIV / 2);
        wait_valid(seen);
        chk(seen && word_a_o == 16'h0123 && word_b_o == 16'h0456, "R5 timing frame", word_a_o, 16'h0123);
    endtask

    task automatic t_single(input logic [13:0] a, input logic [13:0] b, input logic gv);
        logic seen;
        int   nc;
        int   stray = 0;
        mdl_a = a;
        mdl_b = b;
        gap_val = gv;
        @(negedge clk) en = 1'b1;
        @(posedge conv_o);
        @(negedge clk) en = 1'b0;
        wait_valid(seen);
        chk(seen, "R8 valid seen", seen, 1);
        chk(word_a_o == {2'b00, a}, "R5 first word", word_a_o, {2'b00, a});
        chk(word_b_o == {2'b00, b}, "R6 second word", word_b_o, {2'b00, b});
        chk(word_a_o[15:14] == 0 && word_b_o[15:14] == 0, "R7 upper bits", {word_a_o[15:14], word_b_o[15:14]}, 0);
        chk(t_valid == t_fall, "R8 valid on last fall", int'(t_valid), int'(t_fall));
        @(negedge clk);
        chk(!valid_o, "R8 one cycle", valid_o, 0);
        nc = nconv;
        for (int i = 0; i < 150; i++) begin
            @(negedge clk);
            if (sclk_o || conv_o) stray++;
            if (word_a_o != {2'b00, a} || word_b_o != {2'b00, b}) stray++;
        end
        chk(stray == 0 && nconv == nc, "R10 idle after frame", stray, 0);
        chk(word_a_o == {2'b00, a}, "R9 hold", word_a_o, {2'b00, a});
    endtask

    task automatic t_stream(input logic [13:0] a, input logic [13:0] b);
        logic seen;
        int   bad = 0;
        mdl_a = a;
        mdl_b = b;
        @(negedge clk) en = 1'b1;
        for (int f = 0; f < 3; f++) begin
            wait_valid(seen);
            if (!seen || word_a_o != {2'b00, a} || word_b_o != {2'b00, b}) bad++;
        end
        chk(bad == 0, "R5 R6 streamed words", bad, 0);
        chk(last_gap == 32, "R4 edges per frame", last_gap, 32);
        @(negedge clk) en = 1'b0;
        wait_valid(seen);
        repeat (2 * DIV) @(negedge clk);
        begin
            int nc = nconv;
            int stray = 0;
            for (int i = 0; i < 100; i++) begin
                @(negedge clk);
                if (sclk_o) stray++;
            end
            chk(stray == 0 && nconv == nc, "R10 stop after stream", stray, 0);
        end
    endtask

    initial begin
        #700000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_timing();
        t_single(14'h3FFF, 14'h0000, 1'b0);
        t_single(14'h0000, 14'h3FFF, 1'b1);
        t_single(14'h2AAA, 14'h1555, 1'b1);
        t_single(14'h2AAA, 14'h1555, 1'b0);
        t_single(14'h2001, 14'h0003, 1'b1);
        t_stream(14'h1234, 14'h2C0F);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule